// File: doc/BRIEF.md
# Input Change Detector and Interrupt Combiner

This block watches an eight-bit general-purpose input port. All eight inputs are brought into the clock domain and can be read back as levels. Only the low four inputs have change tracking. A change on one of those inputs latches a per-input change flag. When the host has enabled that input, the change also latches an input-change status bit.

The input-change status bit is combined with seven other interrupt sources into an eight-bit status byte. Those sources are transmit ready, receive ready and break change for two channels, and one counter-ready line. They arrive as levels from neighbouring logic. The status byte is gated by a host-written mask and drives an active-low interrupt line.

The host reaches the block through a small register port. It uses a three-bit select, read and write strobes, and a registered read-data bus. Reading the change register clears the latched change flags.

Top module: `gpin_irq_hub`

## Requirements
- R1: A synchronous active-high reset clears the following, and `irq_n` is 1 after reset:
  - the mask register;
  - the change-enable register;
  - all four change flags;
  - the input-change status bit.
- R2: Select 0 (levels) reads the synchronized levels of all eight inputs, with input k in bit k. A new input level is visible to a read issued two rising edges after the change.
- R3: Select 1 (change) reads the change flags of inputs 3..0 in bits 7..4 and the present levels of inputs 3..0 in bits 3..0.
- R4: A change on input k (k < 4) sets change flag k at the third rising edge after the change. Flags latch whatever the enable setting is. Inputs 7..4 never set a flag.
- R5: Status bit 7 (input change) is set by a change on input k only when bit k of the change-enable register (select 4, bits 3..0) is 1. The enable register reads back with bits 7..4 as 0.
- R6: A read of select 1 clears all four change flags and status bit 7. A change detected at the same edge as that read still sets its flag and the status bit.
- R7: Select 2 (status) reads the status byte. From bit 7 down its bits are:
  - input change;
  - break change B;
  - receive ready B;
  - transmit ready B;
  - counter ready;
  - break change A;
  - receive ready A;
  - transmit ready A.

  Bits 6..0 follow their source inputs directly.
- R8: Select 3 (mask) is written and read with the same bit positions as the status byte. `irq_n` is 0 exactly when some status bit and its mask bit are both 1. Writes go only to selects 3 and 4.
- R9: A read captures data on `reg_rdata` at the rising edge where `reg_rd` is 1. `reg_rdata` holds that value until the next read.
- R10: Input levels present when reset is released produce no change flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Asynchronous general-purpose inputs |
| tx_rdy_a | input | 1 | Transmit ready, channel A (level) |
| rx_rdy_a | input | 1 | Receive ready, channel A (level) |
| brk_chg_a | input | 1 | Break change, channel A (level) |
| ctr_rdy | input | 1 | Counter ready (level) |
| tx_rdy_b | input | 1 | Transmit ready, channel B (level) |
| rx_rdy_b | input | 1 | Receive ready, channel B (level) |
| brk_chg_b | input | 1 | Break change, channel B (level) |
| reg_sel | input | 3 | Register select: 0 levels, 1 change, 2 status, 3 mask, 4 enable |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low combined interrupt |

## Verification
Each result has its own latency after the stimulus that causes it:
- A pin change sets its flag and pulls `irq_n` low at the third rising edge after the change. The bench samples `irq_n` at the falling edges after the second and the third edge, and expects the line high at the first and low at the second.
- Source levels and mask writes reach `irq_n` within the cycle. They are sampled at the next falling edge.
- Read data appears one edge after the strobe.

The same-edge case of R6 is hit by placing a read strobe on the third edge after a change. The bench then expects the old flags from that read and the new flag from the read that follows.

// File: rtl/gpin_irq_pkg.sv
package gpin_irq_pkg;

    localparam int PORT_W = 8;
    localparam int CHG_W  = 4;
    localparam int STAT_W = 8;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_LEVELS = 3'd0,
        SEL_CHANGE = 3'd1,
        SEL_STATUS = 3'd2,
        SEL_MASK   = 3'd3,
        SEL_ENABLE = 3'd4
    } reg_sel_e;

    // Secondary sources, packed so that they land in status bits 6..0.
    typedef struct packed {
        logic brk_b;
        logic rx_b;
        logic tx_b;
        logic ctr;
        logic brk_a;
        logic rx_a;
        logic tx_a;
    } src_t;

    typedef struct packed {
        logic in_chg;
        src_t src;
    } stat_t;

    function automatic logic [PORT_W-1:0] pack_change(
        input logic [CHG_W-1:0] flags,
        input logic [CHG_W-1:0] levels
    );
        return {flags, levels};
    endfunction

endpackage

// File: rtl/gpin_sync.sv
module gpin_sync #(
    parameter int W      = 8,
    parameter int CW     = 4,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  pin,
    output logic [W-1:0]  lvl,
    output logic [CW-1:0] chg
);
    localparam int PRIME_N = STAGES + 1;
    localparam int CNT_W   = $clog2(PRIME_N + 1);

    logic [STAGES-1:0][W-1:0] stage_q;
    logic [CW-1:0]            hist_q;
    logic [CNT_W-1:0]         prime_q;
    logic                     primed;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= pin;
            for (int k = 1; k < STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign lvl = stage_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            hist_q <= lvl[CW-1:0];
        end
    end

    // Suppress detection until the chain and history hold real samples.
    always_ff @(posedge clk) begin
        if (rst) begin
            prime_q <= '0;
        end else if (!primed) begin
            prime_q <= prime_q + CNT_W'(1);
        end
    end

    assign primed = (prime_q == CNT_W'(PRIME_N));
    assign chg    = primed ? (lvl[CW-1:0] ^ hist_q) : '0;

    AST_NO_EARLY_CHG: assert property (@(posedge clk) disable iff (rst)
        (chg != '0) |-> $stable(prime_q)) else $error("early change"); // R10

endmodule

// File: rtl/gpin_delta.sv
module gpin_delta #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] chg,
    input  logic [CW-1:0] en,
    input  logic          clr,
    output logic [CW-1:0] delta,
    output logic          ic
);
    logic [CW-1:0] delta_q;
    logic [CW-1:0] delta_d;
    logic          ic_q;
    logic          ic_d;

    generate
        for (genvar i = 0; i < CW; i++) begin : g_flag
            // A new change wins over a clear at the same edge.
            assign delta_d[i] = chg[i] | (delta_q[i] & ~clr);
        end
    endgenerate

    assign ic_d = (|(chg & en)) | (ic_q & ~clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            delta_q <= '0;
            ic_q    <= 1'b0;
        end else begin
            delta_q <= delta_d;
            ic_q    <= ic_d;
        end
    end

    assign delta = delta_q;
    assign ic    = ic_q;

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (clr && chg == '0) |=> (delta == '0 && !ic)) else $error("clear"); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (chg != '0) |=> ((delta & $past(chg)) == $past(chg))) else $error("set"); // R4
    AST_IC_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(ic) |-> $past((chg & en) != '0)) else $error("enable"); // R5
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr && chg == '0) |=> $stable(delta)) else $error("hold"); // R4

endmodule

// File: rtl/gpin_regs.sv
module gpin_regs
    import gpin_irq_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [DW-1:0]    reg_wdata,
    input  logic [DW-1:0]    lvl_byte,
    input  logic [DW-1:0]    chg_byte,
    input  logic [DW-1:0]    stat_byte,
    output logic [DW-1:0]    mask,
    output logic [CW-1:0]    en,
    output logic [DW-1:0]    rdata,
    output logic             rd_clr
);
    reg_sel_e      sel;
    logic [DW-1:0] mask_q;
    logic [CW-1:0] en_q;
    logic [DW-1:0] rdata_q;
    logic [DW-1:0] rd_mux;

    assign sel = reg_sel_e'(reg_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            en_q   <= '0;
        end else if (reg_wr) begin
            if (sel == SEL_MASK)   mask_q <= reg_wdata;
            if (sel == SEL_ENABLE) en_q   <= reg_wdata[CW-1:0];
        end
    end

    always_comb begin
        case (sel)
            SEL_LEVELS: rd_mux = lvl_byte;
            SEL_CHANGE: rd_mux = chg_byte;
            SEL_STATUS: rd_mux = stat_byte;
            SEL_MASK:   rd_mux = mask_q;
            SEL_ENABLE: rd_mux = {{(DW-CW){1'b0}}, en_q};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign rd_clr = reg_rd && (sel == SEL_CHANGE);
    assign mask   = mask_q;
    assign en     = en_q;
    assign rdata  = rdata_q;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(rdata)) else $error("rdata moved"); // R9
    AST_MASK_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && sel == SEL_MASK) |=> $stable(mask)) else $error("mask moved"); // R8
    AST_EN_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && sel == SEL_ENABLE) |=> $stable(en)) else $error("enable moved"); // R5

endmodule

// File: rtl/irq_combine.sv
module irq_combine
    import gpin_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ic,
    input  src_t              src,
    input  logic [STAT_W-1:0] mask,
    output stat_t             status,
    output logic              irq_n
);
    logic [STAT_W-1:0] hit;
    logic [STAT_W-1:0] stat_v;

    assign status.in_chg = ic;
    assign status.src    = src;
    assign stat_v        = status;

    generate
        for (genvar i = 0; i < STAT_W; i++) begin : g_hit
            assign hit[i] = stat_v[i] & mask[i];
        end
    endgenerate

    assign irq_n = ~(|hit);

    AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> irq_n) else $error("masked irq"); // R8
    AST_IC_ROUTES: assert property (@(posedge clk) disable iff (rst)
        (ic && mask[STAT_W-1]) |-> !irq_n) else $error("ic route"); // R8

endmodule

// File: rtl/gpin_irq_hub.sv
module gpin_irq_hub
    import gpin_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] pin_in,
    input  logic              tx_rdy_a,
    input  logic              rx_rdy_a,
    input  logic              brk_chg_a,
    input  logic              ctr_rdy,
    input  logic              tx_rdy_b,
    input  logic              rx_rdy_b,
    input  logic              brk_chg_b,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [PORT_W-1:0] reg_wdata,
    output logic [PORT_W-1:0] reg_rdata,
    output logic              irq_n
);
    logic [PORT_W-1:0] lvl;
    logic [CHG_W-1:0]  chg;
    logic [CHG_W-1:0]  delta;
    logic [CHG_W-1:0]  en;
    logic              ic;
    logic              rd_clr;
    logic [STAT_W-1:0] mask;
    src_t              src;
    stat_t             status;

    assign src = '{brk_b: brk_chg_b, rx_b: rx_rdy_b, tx_b: tx_rdy_b, ctr: ctr_rdy,
                   brk_a: brk_chg_a, rx_a: rx_rdy_a, tx_a: tx_rdy_a};

    gpin_sync #(.W(PORT_W), .CW(CHG_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .pin(pin_in), .lvl(lvl), .chg(chg)
    );

    gpin_delta #(.CW(CHG_W)) delta_i (
        .clk(clk), .rst(rst), .chg(chg), .en(en), .clr(rd_clr),
        .delta(delta), .ic(ic)
    );

    irq_combine comb_i (
        .clk(clk), .rst(rst), .ic(ic), .src(src), .mask(mask),
        .status(status), .irq_n(irq_n)
    );

    gpin_regs #(.DW(PORT_W), .CW(CHG_W)) regs_i (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .lvl_byte(lvl),
        .chg_byte(pack_change(delta, lvl[CHG_W-1:0])),
        .stat_byte(status), .mask(mask), .en(en), .rdata(reg_rdata), .rd_clr(rd_clr)
    );

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> ((status & mask) != '0)) else $error("stray irq"); // R8
    AST_RST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (delta == '0 && !ic)) else $error("reset flags"); // R1

endmodule

// File: tb/gpin_irq_hub_tb_top.sv
module gpin_irq_hub_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] pin_in;
    logic [6:0] src_v;
    logic [2:0] reg_sel;
    logic       reg_wr;
    logic       reg_rd;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       irq_n;
    int         n_chk = 0;
    int         n_err = 0;
    int         cyc   = 0;
    bit         done  = 0;

    always #2 clk = ~clk;

    gpin_irq_hub dut_i (
        .clk(clk), .rst(rst), .pin_in(pin_in),
        .tx_rdy_a(src_v[0]), .rx_rdy_a(src_v[1]), .brk_chg_a(src_v[2]), .ctr_rdy(src_v[3]),
        .tx_rdy_b(src_v[4]), .rx_rdy_b(src_v[5]), .brk_chg_b(src_v[6]),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);
        rd_reg(3'd3, d); chk("R1 mask reset", d, 8'h00);
        rd_reg(3'd4, d); chk("R1 enable reset", d, 8'h00);
        rd_reg(3'd2, d); chk("R1 status reset", d, 8'h00);
        rd_reg(3'd1, d); chk("R10 no flags from reset levels", d, 8'h05);
        rd_reg(3'd0, d); chk("R2 levels after reset", d, 8'hA5);
    endtask

    task automatic t_levels();
        logic [7:0] d;
        set_pins(8'h3C);
        @(negedge clk);
        @(negedge clk);
        reg_sel = 3'd0; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        chk("R2 level read two edges after change", reg_rdata, 8'h3C);
        set_pins(8'hA5);
        settle();
        rd_reg(3'd1, d);
        chk("R3 flags from 3C/A5 step", d, 8'h95);
        rd_reg(3'd1, d); chk("R6 flags cleared", d, 8'h05);
    endtask

    task automatic t_change_timing();
        logic [7:0] d;
        wr_reg(3'd4, 8'h0F);
        wr_reg(3'd3, 8'h80);
        set_pins(8'hA7);
        @(negedge clk); @(negedge clk);
        chk("R4 irq_n still high after two edges", {7'd0, irq_n}, 8'h01);
        @(negedge clk);
        chk("R4 irq_n low after third edge", {7'd0, irq_n}, 8'h00);
        rd_reg(3'd2, d); chk("R7 status bit7 input change", d, 8'h80);
        rd_reg(3'd1, d); chk("R3 change pin1 layout", d, 8'h27);
        chk("R6 irq_n released by change read", {7'd0, irq_n}, 8'h01);
        rd_reg(3'd1, d); chk("R6 flags cleared after read", d, 8'h07);
    endtask

    task automatic t_enable_gate();
        logic [7:0] d;
        wr_reg(3'd4, 8'hF1);
        rd_reg(3'd4, d); chk("R5 enable readback upper zero", d, 8'h01);
        set_pins(8'hA3);
        settle();
        chk("R5 disabled input no irq", {7'd0, irq_n}, 8'h01);
        rd_reg(3'd2, d); chk("R5 status bit7 clear", d, 8'h00);
        rd_reg(3'd1, d); chk("R4 flag latches while disabled", d, 8'h43);
        wr_reg(3'd4, 8'h0F);
        chk("R5 late enable raises nothing", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_upper_pins();
        logic [7:0] d;
        set_pins(8'h53);
        settle();
        chk("R4 upper pins no irq", {7'd0, irq_n}, 8'h01);
        rd_reg(3'd1, d); chk("R4 upper pins no flag", d, 8'h03);
        rd_reg(3'd0, d); chk("R2 upper levels", d, 8'h53);
        set_pins(8'h5A);
        settle();
        rd_reg(3'd1, d); chk("R3 two flags pins 0 and 3", d, 8'h9A);
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        set_pins(8'h52);
        @(negedge clk); @(negedge clk);
        reg_sel = 3'd1; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        chk("R6 same-edge read sees old flags", reg_rdata, 8'h02);
        chk("R6 same-edge change raises irq", {7'd0, irq_n}, 8'h00);
        rd_reg(3'd1, d); chk("R6 same-edge change kept", d, 8'h82);
        chk("R6 irq cleared", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_sources();
        logic [7:0] d;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            src_v = 7'(1 << i);
            wr_reg(3'd3, 8'(1 << i));
            chk("R8 unmasked source asserts irq", {7'd0, irq_n}, 8'h00);
            rd_reg(3'd2, d); chk("R7 source bit position", d, 8'(1 << i));
            wr_reg(3'd3, 8'h7F & ~8'(1 << i));
            chk("R8 masked source no irq", {7'd0, irq_n}, 8'h01);
        end
        @(negedge clk);
        src_v = '0;
        wr_reg(3'd3, 8'h5A);
        rd_reg(3'd3, d); chk("R8 mask readback", d, 8'h5A);
        wr_reg(3'd2, 8'hFF);
        rd_reg(3'd3, d); chk("R8 write to status ignored", d, 8'h5A);
    endtask

    task automatic t_rdata_hold();
        logic [7:0] d;
        rd_reg(3'd0, d); chk("R9 read value", d, 8'h52);
        set_pins(8'h00);
        @(negedge clk);
        src_v = 7'h7F;
        settle();
        chk("R9 rdata held without read", reg_rdata, 8'h52);
        src_v = '0;
        rd_reg(3'd1, d);
    endtask

    initial begin
        rst = 1'b1; pin_in = 8'hA5; src_v = '0;
        reg_sel = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle();
        t_reset();
        t_levels();
        t_change_timing();
        t_enable_gate();
        t_upper_pins();
        t_set_wins();
        t_sources();
        t_rdata_hold();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule